// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block keeps the descriptor table of a simple Ethernet MAC and walks it on behalf of the MAC. One shared table holds a transmit ring followed by a receive ring. The split point between the two rings is a register the host programs. The host reads and writes the table and a few control registers through a 32-bit register port. Each descriptor has two words: a status word, then a buffer address word.

On the MAC side, the block presents the current transmit descriptor while it is owned by hardware. The MAC reports each finished transmission with a status code, and the block writes that code back into the descriptor and moves to the next one. On receive, the block presents the current empty descriptor. The MAC reports each finished frame with its length and error flags, and the block fills in the descriptor and moves on. If no empty descriptor is available, the frame is dropped and the drop is flagged. Each ring returns to its first entry on a descriptor's wrap flag or at the end of the ring.

Completion events latch into a sticky source register whether or not they are masked. The interrupt output is asserted while any source bit is set whose mask bit is also set. Frame buffers, data movement and the MAC datapath lie outside the block.

Top module: `eth_bd_ring`

## Requirements
- R1: After reset, every register and every descriptor word reads 0, and `irq`, `tx_valid` and `rx_valid` are low.
- R2: Register map:
  - 0x00 is control: bit 0 enables receive, bit 1 enables transmit.
  - 0x04 is the interrupt source register and 0x08 is the interrupt mask, each 5 bits wide.
  - 0x20 is the transmit descriptor count.
  - Descriptor n has its status word at 0x400+8n and its address word at 0x404+8n.
  - `csr_rdata` shows the word at `csr_addr` one cycle later. A descriptor index at or above NUM_BD reads 0.
- R3: A count write larger than NUM_BD stores NUM_BD. Any count write returns the transmit pointer to index 0 and the receive pointer to index count.
- R4: Transmit offer:
  - `tx_valid` is high exactly when transmit is enabled, the count is nonzero, and bit 15 (ready) of the current descriptor is 1.
  - With it, the block presents the address word, the length from status [31:16], pad from bit 12, and CRC-enable from bit 11.
- R5: Transmit completion:
  - A `tx_done` pulse while `tx_valid` is high rewrites the status word. Bits [31:16] and [14:9] are kept, bit 15 becomes 0, and bits [8:0] become `tx_stat`. The pointer then advances.
  - `tx_done` while `tx_valid` is low changes nothing.
- R6: When bit 14 (irq) of the completed transmit descriptor is set, the block raises a source bit:
  - bit 1 if any of `tx_stat` bits 8, 3, 2, 1 or 0 is set;
  - bit 0 otherwise.
  - Retry count bits [7:4] are not errors. With bit 14 clear, no source bit is set.
- R7: Receive completion:
  - `rx_valid` is high exactly when receive is enabled, count < NUM_BD, and bit 15 (empty) of the current descriptor is 1.
  - An `rx_done` pulse while `rx_valid` is high writes `rx_len` into [31:16], clears bit 15, keeps [14:9], writes `rx_err` into [8:0], and advances the pointer.
  - `rx_len` is stored as given, including the 4-byte frame check sequence.
- R8: Receive drop:
  - An `rx_done` while receive is enabled, when there is no empty current descriptor (including an empty receive ring), sets source bit 4. The table and the pointer are left unchanged.
  - With receive disabled, `rx_done` has no effect.
- R9: A pointer returns to the first entry of its ring after completing a descriptor that has bit 13 (wrap) set, or after the last entry of the ring. The first entries are index 0 for transmit and index count for receive. The last entries are index count-1 for transmit and index NUM_BD-1 for receive.
- R10: Source bits are set by events regardless of the mask. Writing 1 to a source bit clears it. An event in the same cycle as the clear leaves the bit set.
- R11: `irq` is high exactly when some source bit and its mask bit are both 1.
- R12: When bit 14 of the completed receive descriptor is set, the block raises a source bit:
  - bit 3 if any of `rx_err` [7:0] is set;
  - bit 2 otherwise.
  - `rx_err` bit 8 (control frame) is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 11 | Byte address of the register port |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, one cycle after the address |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Current transmit descriptor is offered |
| tx_buf_addr | output | 32 | Buffer address of the offered transmit descriptor |
| tx_len | output | 16 | Frame length to send |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transmission of the offered descriptor finished |
| tx_stat | input | 9 | Transmit result: underrun, retry count, limit, late collision, defer, carrier lost |
| rx_valid | output | 1 | An empty receive descriptor is offered |
| rx_buf_addr | output | 32 | Buffer address of the offered receive descriptor |
| rx_done | input | 1 | A received frame has ended |
| rx_len | input | 16 | Received length including frame check sequence |
| rx_err | input | 9 | Receive flags: bit 8 control frame, bits 7:0 errors |

## Verification
A pointer that is off by one shows up at once as the wrong `tx_buf_addr` or `rx_buf_addr` in the cycle after a completion. A wrong wrap decision also shows at once, as a `tx_valid` that should have dropped to 0 at a consumed descriptor. A bad write-back is visible on the next read of the status word. It also shows within one completion as a missing or wrong source bit, because the ownership bit and the interrupt choice both come from that descriptor. Sticky-source faults show on `irq` in the cycle after the event or the clear.

// File: rtl/ethbd_pkg.sv
// Shared constants for the descriptor ring engine: register offsets,
// descriptor flag positions, interrupt source positions and error tests.
package ethbd_pkg;
    localparam int unsigned CSR_AW = 11;
    localparam logic [CSR_AW-1:0] A_CTRL  = 11'h000;
    localparam logic [CSR_AW-1:0] A_SRC   = 11'h004;
    localparam logic [CSR_AW-1:0] A_MASK  = 11'h008;
    localparam logic [CSR_AW-1:0] A_TXCNT = 11'h020;
    localparam int unsigned TBL_BIT = 10;

    localparam int unsigned B_OWN  = 15;
    localparam int unsigned B_IRQ  = 14;
    localparam int unsigned B_WRAP = 13;
    localparam int unsigned B_PAD  = 12;
    localparam int unsigned B_CRC  = 11;
    localparam int unsigned FST_W  = 9;

    localparam int unsigned I_TXF  = 0;
    localparam int unsigned I_TXE  = 1;
    localparam int unsigned I_RXF  = 2;
    localparam int unsigned I_RXE  = 3;
    localparam int unsigned I_BUSY = 4;
    localparam int unsigned SRC_W  = 5;

    localparam int unsigned C_RXEN = 0;
    localparam int unsigned C_TXEN = 1;

    // Transmit result counts as failed on underrun or any of the low flags.
    function automatic logic tx_failed(input logic [FST_W-1:0] s);
        return s[8] | (|s[3:0]);
    endfunction

    // Receive result counts as failed on any flag except control frame.
    function automatic logic rx_failed(input logic [FST_W-1:0] s);
        return |s[7:0];
    endfunction
endpackage

// File: rtl/ethbd_table.sv
// Descriptor storage: NUM_BD pairs of {status, address} words in flops.
// Assumes the two engines never write the same descriptor in one cycle
// (their rings are disjoint). Engine write-backs win over a host write to
// the same status word; address words are written only by the host.
module ethbd_table
    import ethbd_pkg::*;
#(
    parameter int unsigned NUM_BD = 16,
    localparam int unsigned IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1,
    localparam int unsigned WIDX_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WIDX_W-1:0] host_word,
    input  logic [31:0]       host_wdata,
    input  logic [WIDX_W-1:0] host_rword,
    output logic [31:0]       host_rdata,
    input  logic              tx_we,
    input  logic [IDX_W-1:0]  tx_idx,
    input  logic [31:0]       tx_wdata,
    output logic [31:0]       tx_stat,
    output logic [31:0]       tx_addr,
    input  logic              rx_we,
    input  logic [IDX_W-1:0]  rx_idx,
    input  logic [31:0]       rx_wdata,
    output logic [31:0]       rx_stat,
    output logic [31:0]       rx_addr
);
    logic [31:0] stat_arr [NUM_BD];
    logic [31:0] addr_arr [NUM_BD];

    for (genvar gi = 0; gi < NUM_BD; gi++) begin : g_bd
        logic [31:0] stat_q;
        logic [31:0] addr_q;
        // Per-descriptor words with write priority receive > transmit > host.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q <= '0;
                addr_q <= '0;
            end else begin
                if (rx_we && rx_idx == IDX_W'(gi))
                    stat_q <= rx_wdata;
                else if (tx_we && tx_idx == IDX_W'(gi))
                    stat_q <= tx_wdata;
                else if (host_we && host_word == WIDX_W'(2 * gi))
                    stat_q <= host_wdata;
                if (host_we && host_word == WIDX_W'(2 * gi + 1))
                    addr_q <= host_wdata;
            end
        end
        assign stat_arr[gi] = stat_q;
        assign addr_arr[gi] = addr_q;
    end

    // Read ports: host (status or address by word index) and both engines.
    always_comb begin
        host_rdata = host_rword[0] ? addr_arr[host_rword[WIDX_W-1:1]]
                                   : stat_arr[host_rword[WIDX_W-1:1]];
        tx_stat = stat_arr[tx_idx];
        tx_addr = addr_arr[tx_idx];
        rx_stat = stat_arr[rx_idx];
        rx_addr = addr_arr[rx_idx];
    end

    // R5: a transmit write-back leaves the descriptor owned by software.
    a_r5_tx_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |=> !stat_arr[$past(tx_idx)][B_OWN]);
    // R7: a receive write-back leaves the descriptor no longer empty.
    a_r7_rx_wb_fills: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |=> !stat_arr[$past(rx_idx)][B_OWN]);
endmodule

// File: rtl/ethbd_csr.sv
// Control, interrupt source/mask and transmit-count registers.
// Assumes event inputs are single-cycle pulses from the ring engines.
// The count write is also exported combinationally so that both engines
// reload their pointers on the same edge that the count changes.
module ethbd_csr
    import ethbd_pkg::*;
#(
    parameter int unsigned NUM_BD = 16,
    localparam int unsigned CNT_W = $clog2(NUM_BD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CSR_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [SRC_W-1:0]  ev,
    output logic              tx_en,
    output logic              rx_en,
    output logic [SRC_W-1:0]  mask,
    output logic [SRC_W-1:0]  src,
    output logic [CNT_W-1:0]  tx_count,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              irq
);
    logic [SRC_W-1:0] clr;

    // Decode of the count write, saturated to the table size.
    always_comb begin
        cnt_load = we && addr == A_TXCNT;
        cnt_val  = (wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : wdata[CNT_W-1:0];
        clr      = (we && addr == A_SRC) ? wdata[SRC_W-1:0] : '0;
    end

    // Enables, mask and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
            mask     <= '0;
            tx_count <= '0;
        end else begin
            if (we && addr == A_CTRL) begin
                tx_en <= wdata[C_TXEN];
                rx_en <= wdata[C_RXEN];
            end
            if (we && addr == A_MASK)
                mask <= wdata[SRC_W-1:0];
            if (cnt_load)
                tx_count <= cnt_val;
        end
    end

    // Sticky sources: write-one-to-clear, a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src <= '0;
        else
            src <= (src & ~clr) | ev;
    end

    assign irq = |(src & mask);

    // R10: every event is visible in the source register one cycle later.
    a_r10_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((src & $past(ev)) == $past(ev)));
    // R3: the stored count never exceeds the table size.
    a_r3_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CNT_W'(NUM_BD));
endmodule

// File: rtl/ethbd_tx_ring.sv
// Transmit ring walker: offers the current descriptor while it is owned
// by hardware, writes the MAC's result back on completion and advances.
// Assumes tx_done is a one-cycle pulse and is ignored unless offered.
module ethbd_tx_ring
    import ethbd_pkg::*;
#(
    parameter int unsigned NUM_BD = 16,
    localparam int unsigned IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1,
    localparam int unsigned CNT_W = $clog2(NUM_BD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic             load,
    input  logic [31:0]      stat,
    input  logic             done,
    input  logic [FST_W-1:0] done_st,
    output logic [IDX_W-1:0] ptr,
    output logic             offer,
    output logic             wb_we,
    output logic [31:0]      wb_data,
    output logic             ev_ok,
    output logic             ev_err
);
    logic last;
    logic [FST_W-1:0] unused_old_flags;

    // Offer, write-back word and completion events.
    always_comb begin
        offer   = en && count != '0 && stat[B_OWN];
        wb_we   = done && offer;
        wb_data = {stat[31:16], 1'b0, stat[14:9], done_st};
        ev_ok   = wb_we && stat[B_IRQ] && !tx_failed(done_st);
        ev_err  = wb_we && stat[B_IRQ] && tx_failed(done_st);
        last    = stat[B_WRAP] || (CNT_W'(ptr) == count - 1'b1);
    end
    assign unused_old_flags = stat[FST_W-1:0];

    // Pointer: reload on count write, advance or wrap on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            ptr <= '0;
        else if (wb_we)
            ptr <= last ? '0 : ptr + 1'b1;
    end

    // R9: the pointer stays inside the transmit ring.
    a_r9_tx_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (CNT_W'(ptr) < count));
    // R5: an accepted completion moves the pointer unless the ring is one long.
    a_r5_tx_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && !load && count > CNT_W'(1) && !stat[B_WRAP]) |=> ptr != $past(ptr));
endmodule

// File: rtl/ethbd_rx_ring.sv
// Receive ring walker: offers the current empty descriptor, fills it in
// when a frame ends, and flags a drop when no empty descriptor exists.
// Assumes rx_done is a one-cycle pulse at the end of each frame.
module ethbd_rx_ring
    import ethbd_pkg::*;
#(
    parameter int unsigned NUM_BD = 16,
    localparam int unsigned IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1,
    localparam int unsigned CNT_W = $clog2(NUM_BD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [31:0]      stat,
    input  logic             done,
    input  logic [15:0]      done_len,
    input  logic [FST_W-1:0] done_err,
    output logic [IDX_W-1:0] ptr,
    output logic             offer,
    output logic             wb_we,
    output logic [31:0]      wb_data,
    output logic             ev_ok,
    output logic             ev_err,
    output logic             ev_busy
);
    logic has_ring;
    logic last;
    logic [24:0] unused_old;

    // Offer, write-back word, completion and drop events.
    always_comb begin
        has_ring = count < CNT_W'(NUM_BD);
        offer    = en && has_ring && stat[B_OWN];
        wb_we    = done && offer;
        wb_data  = {done_len, 1'b0, stat[14:9], done_err};
        ev_ok    = wb_we && stat[B_IRQ] && !rx_failed(done_err);
        ev_err   = wb_we && stat[B_IRQ] && rx_failed(done_err);
        ev_busy  = done && en && !offer;
        last     = stat[B_WRAP] || (ptr == IDX_W'(NUM_BD - 1));
    end
    assign unused_old = {stat[31:16], stat[FST_W-1:0]};

    // Pointer: reload to the ring start on count write, advance or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= IDX_W'(load_val);
        else if (wb_we)
            ptr <= last ? IDX_W'(count) : ptr + 1'b1;
    end

    // R9: the pointer stays inside the receive ring.
    a_r9_rx_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        has_ring |-> (CNT_W'(ptr) >= count));
    // R8: a dropped frame leaves the pointer where it was.
    a_r8_drop_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_busy && !load) |=> $stable(ptr));
endmodule

// File: rtl/eth_bd_ring.sv
// Top of the descriptor ring engine: decodes the register port, shares
// the descriptor table between host and both ring walkers, and collects
// completion events into the interrupt registers.
// Assumes NUM_BD is between 2 and 128 so the table fits below 0x800.
module eth_bd_ring
    import ethbd_pkg::*;
#(
    parameter int unsigned NUM_BD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [31:0]       tx_buf_addr,
    output logic [15:0]       tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [FST_W-1:0]  tx_stat,
    output logic              rx_valid,
    output logic [31:0]       rx_buf_addr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [FST_W-1:0]  rx_err
);
    localparam int unsigned IDX_W  = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;
    localparam int unsigned WIDX_W = IDX_W + 1;
    localparam int unsigned CNT_W  = $clog2(NUM_BD + 1);

    logic              tbl_sel, tbl_hit;
    logic [WIDX_W-1:0] host_word;
    logic [31:0]       tbl_rdata, rd_next;
    logic              tx_en, rx_en, cnt_load;
    logic [SRC_W-1:0]  mask, src, ev;
    logic [CNT_W-1:0]  tx_count, cnt_val;
    logic [IDX_W-1:0]  tx_ptr, rx_ptr;
    logic [31:0]       tx_stat_w, tx_addr_w, rx_stat_w, rx_addr_w;
    logic              tx_wb, rx_wb;
    logic [31:0]       tx_wb_data, rx_wb_data;
    logic              tx_ok, tx_bad, rx_ok, rx_bad, rx_busy;

    // Host address decode into the descriptor table.
    always_comb begin
        tbl_sel   = csr_addr[TBL_BIT];
        tbl_hit   = tbl_sel && (32'(csr_addr[9:3]) < NUM_BD);
        host_word = csr_addr[WIDX_W+1:2];
    end

    ethbd_table #(.NUM_BD(NUM_BD)) u_table (
        .clk(clk), .rst_n(rst_n),
        .host_we(csr_we && tbl_hit), .host_word(host_word), .host_wdata(csr_wdata),
        .host_rword(host_word), .host_rdata(tbl_rdata),
        .tx_we(tx_wb), .tx_idx(tx_ptr), .tx_wdata(tx_wb_data),
        .tx_stat(tx_stat_w), .tx_addr(tx_addr_w),
        .rx_we(rx_wb), .rx_idx(rx_ptr), .rx_wdata(rx_wb_data),
        .rx_stat(rx_stat_w), .rx_addr(rx_addr_w)
    );

    assign ev = {rx_busy, rx_bad, rx_ok, tx_bad, tx_ok};

    ethbd_csr #(.NUM_BD(NUM_BD)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .we(csr_we && !tbl_sel), .addr(csr_addr), .wdata(csr_wdata), .ev(ev),
        .tx_en(tx_en), .rx_en(rx_en), .mask(mask), .src(src),
        .tx_count(tx_count), .cnt_load(cnt_load), .cnt_val(cnt_val), .irq(irq)
    );

    ethbd_tx_ring #(.NUM_BD(NUM_BD)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .count(tx_count), .load(cnt_load),
        .stat(tx_stat_w), .done(tx_done), .done_st(tx_stat),
        .ptr(tx_ptr), .offer(tx_valid), .wb_we(tx_wb), .wb_data(tx_wb_data),
        .ev_ok(tx_ok), .ev_err(tx_bad)
    );

    ethbd_rx_ring #(.NUM_BD(NUM_BD)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .count(tx_count), .load(cnt_load),
        .load_val(cnt_val), .stat(rx_stat_w), .done(rx_done), .done_len(rx_len),
        .done_err(rx_err), .ptr(rx_ptr), .offer(rx_valid), .wb_we(rx_wb),
        .wb_data(rx_wb_data), .ev_ok(rx_ok), .ev_err(rx_bad), .ev_busy(rx_busy)
    );

    // Transmit descriptor fields presented to the MAC.
    always_comb begin
        tx_buf_addr = tx_addr_w;
        tx_len      = tx_stat_w[31:16];
        tx_pad      = tx_stat_w[B_PAD];
        tx_crc      = tx_stat_w[B_CRC];
        rx_buf_addr = rx_addr_w;
    end

    // Read multiplexer for the register port.
    always_comb begin
        rd_next = '0;
        if (tbl_sel) begin
            if (tbl_hit)
                rd_next = tbl_rdata;
        end else begin
            unique case (csr_addr)
                A_CTRL:  rd_next = {30'b0, tx_en, rx_en};
                A_SRC:   rd_next = 32'(src);
                A_MASK:  rd_next = 32'(mask);
                A_TXCNT: rd_next = 32'(tx_count);
                default: rd_next = '0;
            endcase
        end
    end

    // Registered read data, one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            csr_rdata <= '0;
        else
            csr_rdata <= rd_next;
    end

    // R8: a frame ending with receive enabled and nothing offered is flagged busy.
    a_r8_drop_flags_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_valid && rx_en) |=> src[I_BUSY]);
    // R4: nothing is offered to the MAC while transmit is disabled.
    a_r4_tx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_valid);
endmodule

// File: tb/tb_eth_bd_ring.sv
module tb_eth_bd_ring;
    localparam int CLK_PERIOD = 10;
    localparam int NBD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq, tx_valid, tx_pad, tx_crc, rx_valid;
    logic [31:0] tx_buf_addr, rx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_stat = '0;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_err = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    eth_bd_ring #(.NUM_BD(NBD)) dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
        .rx_valid(rx_valid), .rx_buf_addr(rx_buf_addr), .rx_done(rx_done),
        .rx_len(rx_len), .rx_err(rx_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        @(negedge clk);
        d = csr_rdata;
    endtask

    task automatic tx_fire(input logic [8:0] st);
        @(negedge clk);
        tx_done = 1'b1; tx_stat = st;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rx_fire(input logic [15:0] len, input logic [8:0] er);
        @(negedge clk);
        rx_done = 1'b1; rx_len = len; rx_err = er;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    function automatic logic [10:0] st_a(input int n);
        return 11'(32'h400 + 8 * n);
    endfunction

    // Expected write-back and source bits, from R5/R6 and R7/R12.
    function automatic logic [31:0] f_tx_wb(input logic [31:0] s, input logic [8:0] st);
        return {s[31:16], 1'b0, s[14:9], st};
    endfunction
    function automatic logic [31:0] f_tx_src(input logic [31:0] s, input logic [8:0] st);
        if (!s[14]) return 32'h0;
        return (st[8] || st[3:0] != 0) ? 32'h2 : 32'h1;
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] model [NBD];
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_valid", 32'(rx_valid), 0);
        rd(11'h004, v); chk("R1 source", v, 0);
        rd(11'h020, v); chk("R1 count", v, 0);
        rd(11'h400, v); chk("R1 table", v, 0);

        // R3 saturation, R2 readback
        wr(11'h020, 200); rd(11'h020, v); chk("R3 count cap", v, NBD);
        wr(11'h020, 4);   rd(11'h020, v); chk("R2 count readback", v, 4);

        // Transmit descriptors
        for (int n = 0; n < 4; n++) wr(st_a(n) + 11'd4, 32'h1000 + 32'(n) * 32'h100);
        wr(st_a(0), 32'h003C_D000);
        wr(st_a(1), 32'h0064_C800);
        wr(st_a(2), 32'h0020_8000);
        wr(11'h008, 32'h1F);
        @(negedge clk); chk("R4 disabled no offer", 32'(tx_valid), 0);
        wr(11'h000, 2);
        @(negedge clk);
        chk("R4 offer", 32'(tx_valid), 1);
        chk("R4 addr", tx_buf_addr, 32'h1000);
        chk("R4 len", 32'(tx_len), 60);
        chk("R4 pad", 32'(tx_pad), 1);
        chk("R4 crc", 32'(tx_crc), 0);
        tx_fire(9'h000);
        rd(st_a(0), v); chk("R5 writeback ok", v, 32'h003C_5000);
        rd(11'h004, v); chk("R6 TXF", v, 32'h1);
        chk("R11 irq set", 32'(irq), 1);
        chk("R5 next addr", tx_buf_addr, 32'h1100);
        chk("R4 crc bit", 32'(tx_crc), 1);
        tx_fire(9'h034);
        rd(st_a(1), v); chk("R5 writeback err", v, 32'h0064_4834);
        rd(11'h004, v); chk("R6 TXE", v, 32'h3);
        wr(11'h004, 32'h3); rd(11'h004, v); chk("R10 clear", v, 0);
        tx_fire(9'h008);
        rd(st_a(2), v); chk("R5 writeback no irq", v, 32'h0020_0008);
        rd(11'h004, v); chk("R6 no irq bit", v, 0);
        chk("R4 not ready", 32'(tx_valid), 0);
        tx_fire(9'h1FF);
        rd(st_a(3), v); chk("R5 done ignored", v, 0);
        rd(11'h004, v); chk("R5 done ignored src", v, 0);
        wr(st_a(3), 32'h0010_8000);
        @(negedge clk); chk("R4 addr3", tx_buf_addr, 32'h1300);
        tx_fire(9'h000);
        chk("R9 last entry stop", 32'(tx_valid), 0);
        wr(st_a(0), 32'h003C_A000);
        @(negedge clk); chk("R9 wrapped to 0", tx_buf_addr, 32'h1000);
        tx_fire(9'h000);
        wr(st_a(1), 32'h0064_8000);
        @(negedge clk); chk("R9 wrap bit", 32'(tx_valid), 0);
        wr(st_a(0), 32'h003C_C000);
        @(negedge clk); chk("R9 wrap addr", tx_buf_addr, 32'h1000);
        // R10: event and clear of the same bit in one cycle
        wr(11'h004, 32'h1F);
        @(negedge clk);
        csr_addr = 11'h004; csr_wdata = 32'h1; csr_we = 1'b1;
        tx_done = 1'b1; tx_stat = 9'h0;
        @(negedge clk);
        csr_we = 1'b0; tx_done = 1'b0;
        rd(11'h004, v); chk("R10 set wins", v, 32'h1);
        wr(11'h000, 0);
        @(negedge clk); chk("R4 disable", 32'(tx_valid), 0);

        // Receive
        wr(11'h020, 4);
        wr(st_a(4) + 11'd4, 32'h8000); wr(st_a(4), 32'h0000_C000);
        wr(st_a(5) + 11'd4, 32'h8100); wr(st_a(5), 32'h0000_E000);
        wr(11'h004, 32'h1F);
        chk("R7 disabled", 32'(rx_valid), 0);
        rx_fire(64, 0);
        rd(11'h004, v); chk("R8 disabled ignored", v, 0);
        rd(st_a(4), v); chk("R8 disabled table", v, 32'h0000_C000);
        wr(11'h000, 1);
        @(negedge clk);
        chk("R7 offer", 32'(rx_valid), 1);
        chk("R7 addr", rx_buf_addr, 32'h8000);
        rx_fire(64, 0);
        rd(st_a(4), v); chk("R7 writeback", v, 32'h0040_4000);
        rd(11'h004, v); chk("R12 RXF", v, 32'h4);
        chk("R7 next addr", rx_buf_addr, 32'h8100);
        rx_fire(70, 9'h102);
        rd(st_a(5), v); chk("R7 writeback err", v, 32'h0046_6102);
        rd(11'h004, v); chk("R12 RXE", v, 32'hC);
        chk("R9 rx wrap", 32'(rx_valid), 0);
        rx_fire(80, 0);
        rd(11'h004, v); chk("R8 busy", v, 32'h1C);
        rd(st_a(4), v); chk("R8 table kept", v, 32'h0040_4000);
        wr(11'h004, 32'h1F);
        wr(st_a(4), 32'h0000_C000);
        @(negedge clk); chk("R8 ptr kept", rx_buf_addr, 32'h8000);
        rx_fire(60, 9'h100);
        rd(11'h004, v); chk("R12 control not error", v, 32'h4);
        rd(st_a(4), v); chk("R7 ctrl writeback", v, 32'h003C_4100);
        wr(11'h004, 32'h1F);
        wr(11'h020, 200);
        @(negedge clk); chk("R7 no rx ring", 32'(rx_valid), 0);
        rx_fire(60, 0);
        rd(11'h004, v); chk("R8 empty ring busy", v, 32'h10);

        // R11 masking, R2 mask readback, out of range
        wr(11'h008, 32'h04); @(negedge clk); chk("R11 masked", 32'(irq), 0);
        wr(11'h008, 32'h10); @(negedge clk); chk("R11 unmasked", 32'(irq), 1);
        rd(11'h008, v); chk("R2 mask", v, 32'h10);
        wr(11'h004, 32'h10); @(negedge clk); chk("R11 cleared", 32'(irq), 0);
        rd(11'h480, v); chk("R2 out of range", v, 0);
        rd(11'h000, v); chk("R2 control", v, 1);

        // Random transmit rings
        void'($urandom(32'd1234));
        wr(11'h008, 0);
        for (int it = 0; it < 30; it++) begin
            int cnt, mp;
            cnt = 1 + int'($urandom % 8);
            wr(11'h000, 0);
            wr(11'h020, 32'(cnt));
            for (int n = 0; n < cnt; n++) begin
                logic [31:0] s;
                s = $urandom; s[15] = 1'b1;
                model[n] = s;
                wr(st_a(n), s);
                wr(st_a(n) + 11'd4, (32'(it) << 16) | 32'(n));
            end
            wr(11'h004, 32'h1F);
            wr(11'h000, 2);
            mp = 0;
            for (int step = 0; step < cnt + 2; step++) begin
                logic [8:0] st;
                @(negedge clk);
                chk("R4 rand offer", 32'(tx_valid), 32'(model[mp][15]));
                if (!model[mp][15]) break;
                chk("R9 rand addr", tx_buf_addr, (32'(it) << 16) | 32'(mp));
                chk("R4 rand len", 32'(tx_len), 32'(model[mp][31:16]));
                st = 9'($urandom);
                tx_fire(st);
                rd(st_a(mp), v); chk("R5 rand writeback", v, f_tx_wb(model[mp], st));
                rd(11'h004, v); chk("R6 rand source", v, f_tx_src(model[mp], st));
                wr(11'h004, 32'h1F);
                model[mp] = f_tx_wb(model[mp], st);
                mp = (model[mp][13] || mp == cnt - 1) ? 0 : mp + 1;
            end
        end
        summary();
    end
endmodule